// File: doc/BRIEF.md
# Ethernet MAC Pause Flow Controller

This block manages pause-based flow control for the transmit side of a full-duplex Ethernet MAC. Host logic programs a 16-bit pause time, one byte at a time, and selects one of four flow-control modes. When sending pause frames is enabled, the block asks the frame transmitter for a pause frame through a request/acknowledge handshake. It can ask once with the programmed time, once with a zero time that releases the link partner, or repeatedly at a refresh interval that keeps the partner paused without gaps. Pause frames never cut into a data frame that has already started.

The receiver reports decoded pause frames as a pulse with the requested number of quanta. When acting on received pauses is enabled, the block loads a quantum timer. While that timer runs, it holds back the start of new data frames. A host transmit request stays pending through the pause. The frame starts as soon as the timer runs out, and the request flag clears only when the transmitter reports that frame done. In half duplex, the mode field only signals whether backpressure-style flow control is wanted.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, fc_mode is 00, and pause_req, tx_start, tx_rts and tx_paused are all low.
- R2: duplex_shadow always equals cfg_full_duplex. hd_flow_on is high exactly when cfg_full_duplex is low and bit 0 of fc_mode is 1 (modes 01 and 11 on, modes 00 and 10 off).
- R3: In full duplex with cfg_tx_pause_en high, mode 01 requests one pause frame whose pause_quanta is the programmed time. ptime_wdata written with ptime_lo_wr sets bits 7:0, and with ptime_hi_wr sets bits 15:8. fc_mode returns to 00 on the acknowledge.
- R4: In full duplex with transmit pause enabled, mode 11 requests one pause frame with pause_quanta 0, and fc_mode returns to 00 on the acknowledge.
- R5: Mode 10 requests a pause frame at once. After each acknowledge, it requests the next one W*QUANTUM_CYCLES+1 cycles after the acknowledge edge, where W is the programmed time divided by two, or 1 if that is zero. This repeats until the mode is rewritten.
- R6: No pause frame is requested while cfg_tx_pause_en is low or cfg_full_duplex is low.
- R7: A pause frame is not requested while a data frame is in flight, that is, between tx_start and tx_done. It is requested in the cycle after the one in which tx_done returns the block to idle.
- R8: Once raised, pause_req stays high with an unchanged pause_quanta until pause_ack.
- R9: With cfg_rx_pause_en high, a rx_pause_valid pulse carrying N>0 makes tx_paused high for exactly N*QUANTUM_CYCLES cycles, starting the cycle after the pulse. No tx_start occurs while it is high.
- R10: A new received pause value reloads the timer and restarts the count. A received value of 0 clears tx_paused in the next cycle.
- R11: With cfg_rx_pause_en low, received pause frames leave tx_paused low and do not delay data frames.
- R12: host_tx_req sets tx_rts. tx_start pulses in the first idle, unpaused cycle with no pause frame pending. tx_rts stays high until tx_done for that frame, then clears.
- R13: When a pause frame and a data frame are both ready in the same idle cycle, the pause frame goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_full_duplex | input | 1 | MAC operates in full duplex |
| cfg_tx_pause_en | input | 1 | Allow sending pause frames |
| cfg_rx_pause_en | input | 1 | Act on received pause frames |
| fc_mode_wr | input | 1 | Write strobe for the mode field |
| fc_mode_wdata | input | 2 | New mode value |
| ptime_lo_wr | input | 1 | Write strobe for pause time bits 7:0 |
| ptime_hi_wr | input | 1 | Write strobe for pause time bits 15:8 |
| ptime_wdata | input | 8 | Pause time byte |
| fc_mode | output | 2 | Current mode (self-clearing for one-shot modes) |
| duplex_shadow | output | 1 | Read-only copy of the duplex setting |
| hd_flow_on | output | 1 | Half-duplex flow control wanted |
| pause_req | output | 1 | Request to the transmitter for a pause frame |
| pause_quanta | output | 16 | Pause time to place in that frame |
| pause_ack | input | 1 | Transmitter finished the pause frame |
| rx_pause_valid | input | 1 | Receiver decoded a valid pause frame |
| rx_pause_quanta | input | 16 | Pause time carried by that frame |
| tx_paused | output | 1 | Received pause timer running |
| host_tx_req | input | 1 | Host asks to send a data frame |
| tx_rts | output | 1 | Data frame pending or in flight |
| tx_start | output | 1 | One-cycle start pulse for a data frame |
| tx_done | input | 1 | Transmitter finished the data frame |

## Verification
The assertions watch the per-cycle rules on every cycle:
- a pending pause request stays stable until it is acknowledged;
- tx_rts holds until its frame is done;
- no pause request appears while a data frame is in flight or while transmit pause is disabled;
- the quantum counters never count up without a load;
- a zero received value cancels the pause at once;
- the pause timer never starts while receive pause is disabled.

Only the bench scenarios can show the exact lengths of received pauses and refresh intervals for random pause times, the one-shot mode clearing, the byte ordering of the pause time, the release of a deferred request right after the pause ends, and the priority of pause frames over data.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    FC_OFF      = 2'b00,
    FC_ONCE     = 2'b01,
    FC_PERIODIC = 2'b10,
    FC_RESUME   = 2'b11
  } fc_mode_e;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'b00,
    ARB_DATA  = 2'b01,
    ARB_PAUSE = 2'b10
  } arb_state_e;

  // quanta to wait after a periodic pause frame before refreshing
  function automatic logic [15:0] refresh_quanta(input logic [15:0] ptime);
    logic [15:0] half;
    half = ptime >> 1;
    return (half == 16'd0) ? 16'd1 : half;
  endfunction

  // pause time placed in a transmitted frame for a given mode
  function automatic logic [15:0] frame_quanta(input fc_mode_e m, input logic [15:0] ptime);
    return (m == FC_RESUME) ? 16'd0 : ptime;
  endfunction

  function automatic logic is_one_shot(input fc_mode_e m);
    return (m == FC_ONCE) || (m == FC_RESUME);
  endfunction

endpackage

// File: rtl/pfc_quanta_timer.sv
module pfc_quanta_timer #(
  parameter int QUANTUM_CYCLES = 64,
  parameter int TW             = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          running,
  output logic          expire
);
  localparam int PW = (QUANTUM_CYCLES > 1) ? $clog2(QUANTUM_CYCLES) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(QUANTUM_CYCLES - 1);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] cnt_q;
  logic          tick;

  assign running = (cnt_q != '0);
  assign tick    = running && (pre_q == PRE_LAST);
  assign expire  = tick && (cnt_q == TW'(1)) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
      pre_q <= '0;
    end else if (running) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q - TW'(1);
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  // R9
  no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt_q <= $past(cnt_q));

  // R10
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> !running);

endmodule

// File: rtl/pfc_mode_ctl.sv
module pfc_mode_ctl
  import pfc_pkg::*;
#(
  parameter int QUANTUM_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        full_duplex,
  input  logic        tx_pause_en,
  input  logic        mode_wr,
  input  logic [1:0]  mode_wdata,
  input  logic        lo_wr,
  input  logic        hi_wr,
  input  logic [7:0]  byte_wdata,
  input  logic        pause_sent,
  output fc_mode_e    mode,
  output logic        pend,
  output logic [15:0] pend_quanta,
  output logic        hd_on
);
  logic [15:0] ptime_q;
  logic        due_q;
  logic        refresh_load;
  logic        refresh_running;
  logic        refresh_expire;
  logic        send_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptime_q <= '0;
    end else begin
      if (lo_wr) ptime_q[7:0]  <= byte_wdata;
      if (hi_wr) ptime_q[15:8] <= byte_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= FC_OFF;
    end else if (mode_wr) begin
      mode <= fc_mode_e'(mode_wdata);
    end else if (pause_sent && is_one_shot(mode)) begin
      mode <= FC_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      due_q <= 1'b0;
    end else if (mode_wr) begin
      due_q <= (fc_mode_e'(mode_wdata) == FC_PERIODIC);
    end else if (pause_sent) begin
      due_q <= 1'b0;
    end else if (refresh_expire && mode == FC_PERIODIC) begin
      due_q <= 1'b1;
    end
  end

  assign refresh_load = pause_sent && (mode == FC_PERIODIC) && !mode_wr;

  pfc_quanta_timer #(
    .QUANTUM_CYCLES(QUANTUM_CYCLES),
    .TW(16)
  ) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (refresh_load),
    .load_val(refresh_quanta(ptime_q)),
    .running (refresh_running),
    .expire  (refresh_expire)
  );

  assign send_ok     = full_duplex && tx_pause_en;
  assign pend        = send_ok && (is_one_shot(mode) || (mode == FC_PERIODIC && due_q));
  assign pend_quanta = frame_quanta(mode, ptime_q);
  assign hd_on       = !full_duplex && mode[0];

  // R3 R4
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_sent && !mode_wr && is_one_shot(mode)) |=> (mode == FC_OFF));

  // R5
  refresh_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_running && !mode_wr && !refresh_expire) |=> !due_q || $past(due_q));

endmodule

// File: rtl/pfc_tx_arb.sv
module pfc_tx_arb
  import pfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pend,
  input  logic [15:0] pend_quanta,
  input  logic        paused,
  input  logic        host_tx_req,
  input  logic        tx_done,
  input  logic        pause_ack,
  output logic        tx_rts,
  output logic        tx_start,
  output logic        pause_req,
  output logic [15:0] pause_quanta,
  output logic        pause_sent
);
  arb_state_e state_q;
  logic       go_pause;
  logic       go_data;
  logic       data_fin;

  assign go_pause   = (state_q == ARB_IDLE) && pend;
  assign go_data    = (state_q == ARB_IDLE) && !pend && tx_rts && !paused;
  assign data_fin   = (state_q == ARB_DATA) && tx_done;
  assign pause_sent = (state_q == ARB_PAUSE) && pause_ack;
  assign tx_start   = go_data;
  assign pause_req  = (state_q == ARB_PAUSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ARB_IDLE;
      pause_quanta <= '0;
    end else begin
      unique case (state_q)
        ARB_IDLE: begin
          if (go_pause) begin
            state_q      <= ARB_PAUSE;
            pause_quanta <= pend_quanta;
          end else if (go_data) begin
            state_q <= ARB_DATA;
          end
        end
        ARB_DATA:  if (tx_done)   state_q <= ARB_IDLE;
        ARB_PAUSE: if (pause_ack) state_q <= ARB_IDLE;
        default:   state_q <= ARB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           tx_rts <= 1'b0;
    else if (host_tx_req) tx_rts <= 1'b1;
    else if (data_fin)    tx_rts <= 1'b0;
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !pause_ack) |=> (pause_req && $stable(pause_quanta)));

  // R12
  rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rts && !data_fin) |=> tx_rts);

  // R7
  no_cut_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_DATA && !tx_done) |=> !pause_req);

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pfc_pkg::*;
#(
  parameter int QUANTUM_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_full_duplex,
  input  logic        cfg_tx_pause_en,
  input  logic        cfg_rx_pause_en,
  input  logic        fc_mode_wr,
  input  logic [1:0]  fc_mode_wdata,
  input  logic        ptime_lo_wr,
  input  logic        ptime_hi_wr,
  input  logic [7:0]  ptime_wdata,
  output logic [1:0]  fc_mode,
  output logic        duplex_shadow,
  output logic        hd_flow_on,
  output logic        pause_req,
  output logic [15:0] pause_quanta,
  input  logic        pause_ack,
  input  logic        rx_pause_valid,
  input  logic [15:0] rx_pause_quanta,
  output logic        tx_paused,
  input  logic        host_tx_req,
  output logic        tx_rts,
  output logic        tx_start,
  input  logic        tx_done
);
  fc_mode_e    mode;
  logic        pend;
  logic [15:0] pend_quanta;
  logic        pause_sent;
  logic        rx_load;
  logic        rx_expire;

  assign duplex_shadow = cfg_full_duplex;
  assign fc_mode       = mode;
  assign rx_load       = rx_pause_valid && cfg_rx_pause_en;

  pfc_mode_ctl #(.QUANTUM_CYCLES(QUANTUM_CYCLES)) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_duplex(cfg_full_duplex),
    .tx_pause_en(cfg_tx_pause_en),
    .mode_wr    (fc_mode_wr),
    .mode_wdata (fc_mode_wdata),
    .lo_wr      (ptime_lo_wr),
    .hi_wr      (ptime_hi_wr),
    .byte_wdata (ptime_wdata),
    .pause_sent (pause_sent),
    .mode       (mode),
    .pend       (pend),
    .pend_quanta(pend_quanta),
    .hd_on      (hd_flow_on)
  );

  pfc_quanta_timer #(.QUANTUM_CYCLES(QUANTUM_CYCLES), .TW(16)) u_rx_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rx_load),
    .load_val(rx_pause_quanta),
    .running (tx_paused),
    .expire  (rx_expire)
  );

  pfc_tx_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend        (pend),
    .pend_quanta (pend_quanta),
    .paused      (tx_paused),
    .host_tx_req (host_tx_req),
    .tx_done     (tx_done),
    .pause_ack   (pause_ack),
    .tx_rts      (tx_rts),
    .tx_start    (tx_start),
    .pause_req   (pause_req),
    .pause_quanta(pause_quanta),
    .pause_sent  (pause_sent)
  );

  // R6
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) |-> $past(cfg_full_duplex && cfg_tx_pause_en));

  // R10
  zero_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pause_valid && cfg_rx_pause_en && rx_pause_quanta == 16'd0) |=> !tx_paused);

  // R11
  rx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rx_pause_en && !tx_paused) |=> !tx_paused);

  // R9
  expire_ends_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_expire && !rx_load) |=> !tx_paused);

endmodule

// File: tb/pause_flow_ctrl_test.sv
module pause_flow_ctrl_test;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_full_duplex = 1'b1, cfg_tx_pause_en = 1'b1, cfg_rx_pause_en = 1'b1;
  logic        fc_mode_wr = 1'b0;
  logic [1:0]  fc_mode_wdata = 2'b00;
  logic        ptime_lo_wr = 1'b0, ptime_hi_wr = 1'b0;
  logic [7:0]  ptime_wdata = 8'h00;
  logic [1:0]  fc_mode;
  logic        duplex_shadow, hd_flow_on, pause_req, tx_paused, tx_rts, tx_start;
  logic [15:0] pause_quanta;
  logic        pause_ack = 1'b0, rx_pause_valid = 1'b0, host_tx_req = 1'b0, tx_done = 1'b0;
  logic [15:0] rx_pause_quanta = 16'h0000;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pause_flow_ctrl #(.QUANTUM_CYCLES(Q)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_full_duplex(cfg_full_duplex), .cfg_tx_pause_en(cfg_tx_pause_en),
    .cfg_rx_pause_en(cfg_rx_pause_en),
    .fc_mode_wr(fc_mode_wr), .fc_mode_wdata(fc_mode_wdata),
    .ptime_lo_wr(ptime_lo_wr), .ptime_hi_wr(ptime_hi_wr), .ptime_wdata(ptime_wdata),
    .fc_mode(fc_mode), .duplex_shadow(duplex_shadow), .hd_flow_on(hd_flow_on),
    .pause_req(pause_req), .pause_quanta(pause_quanta), .pause_ack(pause_ack),
    .rx_pause_valid(rx_pause_valid), .rx_pause_quanta(rx_pause_quanta),
    .tx_paused(tx_paused), .host_tx_req(host_tx_req), .tx_rts(tx_rts),
    .tx_start(tx_start), .tx_done(tx_done)
  );

  function automatic int exp_refresh_cycles(input int t);
    int w;
    w = t / 2;
    if (w < 1) w = 1;
    return w * Q + 1;
  endfunction

  function automatic int exp_pause_cycles(input int n);
    return n * Q;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    fc_mode_wdata = m; fc_mode_wr = 1'b1; tick(); fc_mode_wr = 1'b0;
  endtask

  task automatic write_ptime(input logic [15:0] t);
    ptime_wdata = t[7:0]; ptime_lo_wr = 1'b1; tick(); ptime_lo_wr = 1'b0;
    ptime_wdata = t[15:8]; ptime_hi_wr = 1'b1; tick(); ptime_hi_wr = 1'b0;
  endtask

  task automatic wait_req(input string req);
    int n;
    n = 0;
    while (!pause_req && n < 20) begin tick(); n++; end
    chk(pause_req, req, pause_req, 1);
  endtask

  task automatic ack_pause();
    pause_ack = 1'b1; tick(); pause_ack = 1'b0;
  endtask

  task automatic rx_pause(input logic [15:0] n);
    rx_pause_quanta = n; rx_pause_valid = 1'b1; tick(); rx_pause_valid = 1'b0;
  endtask

  task automatic finish_data();
    tx_done = 1'b1; tick(); tx_done = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    int seen;
    void'($urandom(32'h5eed_1234));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk(fc_mode == 2'b00, "R1", fc_mode, 0);
    chk(!pause_req && !tx_start && !tx_rts && !tx_paused, "R1",
        {pause_req, tx_start, tx_rts, tx_paused}, 0);
    // R2 duplex mirror
    chk(duplex_shadow == 1'b1, "R2", duplex_shadow, 1);

    // R2 / R6 half duplex
    cfg_full_duplex = 1'b0; tick();
    chk(duplex_shadow == 1'b0, "R2", duplex_shadow, 0);
    seen = 0;
    for (int m = 0; m < 4; m++) begin
      write_mode(m[1:0]);
      chk(hd_flow_on == m[0], "R2", hd_flow_on, m[0]);
      repeat (3) begin tick(); if (pause_req) seen++; end
    end
    chk(seen == 0, "R6", seen, 0);
    write_mode(2'b00);
    cfg_full_duplex = 1'b1;

    // R6 transmit pause disabled
    cfg_tx_pause_en = 1'b0;
    write_mode(2'b01);
    seen = 0;
    repeat (10) begin tick(); if (pause_req) seen++; end
    chk(seen == 0, "R6", seen, 0);
    write_mode(2'b00);
    cfg_tx_pause_en = 1'b1;

    // R3 single pause frame, byte order of pause time
    write_ptime(16'h1234);
    write_mode(2'b01);
    wait_req("R3");
    chk(pause_quanta == 16'h1234, "R3", pause_quanta, 16'h1234);
    repeat (3) tick();
    chk(pause_req && pause_quanta == 16'h1234, "R8", pause_quanta, 16'h1234);
    ack_pause();
    chk(!pause_req && fc_mode == 2'b00, "R3", fc_mode, 0);
    seen = 0;
    repeat (6) begin tick(); if (pause_req) seen++; end
    chk(seen == 0, "R3", seen, 0);

    // R4 resume frame with zero time
    write_mode(2'b11);
    wait_req("R4");
    chk(pause_quanta == 16'h0000, "R4", pause_quanta, 0);
    ack_pause();
    chk(fc_mode == 2'b00, "R4", fc_mode, 0);

    // R5 periodic refresh with random pause times
    for (int it = 0; it < 4; it++) begin
      int t;
      t = (it == 0) ? 1 : int'($urandom_range(2, 9));
      write_ptime(16'(t));
      write_mode(2'b10);
      wait_req("R5");
      chk(pause_quanta == 16'(t), "R5", pause_quanta, t);
      for (int p = 0; p < 2; p++) begin
        ack_pause();
        n = 0;
        while (!pause_req && n < 200) begin tick(); n++; end
        chk(n == exp_refresh_cycles(t), "R5", n, exp_refresh_cycles(t));
      end
      fc_mode_wdata = 2'b00; fc_mode_wr = 1'b1; pause_ack = 1'b1; tick();
      fc_mode_wr = 1'b0; pause_ack = 1'b0;
      seen = 0;
      repeat (45) begin tick(); if (pause_req) seen++; end
      chk(seen == 0, "R5", seen, 0);
    end

    // R7 pause frame waits for data frame in flight
    host_tx_req = 1'b1; tick(); host_tx_req = 1'b0;
    chk(tx_start && tx_rts, "R12", tx_start, 1);
    tick();
    write_mode(2'b01);
    seen = 0;
    repeat (5) begin tick(); if (pause_req) seen++; end
    chk(seen == 0, "R7", seen, 0);
    finish_data();
    chk(!tx_rts, "R12", tx_rts, 0);
    tick();
    chk(pause_req, "R7", pause_req, 1);
    ack_pause();

    // R13 pause frame before data
    fc_mode_wdata = 2'b01; fc_mode_wr = 1'b1; host_tx_req = 1'b1; tick();
    fc_mode_wr = 1'b0; host_tx_req = 1'b0;
    chk(!tx_start, "R13", tx_start, 0);
    tick();
    chk(pause_req, "R13", pause_req, 1);
    ack_pause();
    chk(tx_start, "R13", tx_start, 1);
    tick();
    finish_data();

    // R9 random received pause lengths
    for (int it = 0; it < 6; it++) begin
      int q;
      q = int'($urandom_range(1, 12));
      rx_pause(16'(q));
      n = 0;
      while (tx_paused && n < 500) begin tick(); n++; end
      chk(n == exp_pause_cycles(q), "R9", n, exp_pause_cycles(q));
      repeat (int'($urandom_range(1, 4))) tick();
    end

    // R12 / R9 request deferred through a pause
    rx_pause(16'd3);
    host_tx_req = 1'b1; tick(); host_tx_req = 1'b0;
    seen = 0;
    n = 1;
    while (tx_paused && n < 500) begin
      if (tx_start) seen++;
      tick(); n++;
    end
    chk(seen == 0, "R9", seen, 0);
    chk(n == exp_pause_cycles(3), "R9", n, exp_pause_cycles(3));
    chk(tx_start && tx_rts, "R12", tx_start, 1);
    tick();
    repeat (2) tick();
    chk(tx_rts, "R12", tx_rts, 1);
    finish_data();
    chk(!tx_rts, "R12", tx_rts, 0);

    // R10 reload and zero cancel
    rx_pause(16'd10);
    repeat (5) tick();
    rx_pause(16'd2);
    n = 0;
    while (tx_paused && n < 500) begin tick(); n++; end
    chk(n == exp_pause_cycles(2), "R10", n, exp_pause_cycles(2));
    rx_pause(16'd20);
    repeat (3) tick();
    rx_pause(16'd0);
    chk(!tx_paused, "R10", tx_paused, 0);

    // R11 receive pause disabled
    cfg_rx_pause_en = 1'b0;
    rx_pause(16'd5);
    chk(!tx_paused, "R11", tx_paused, 0);
    host_tx_req = 1'b1; tick(); host_tx_req = 1'b0;
    chk(tx_start, "R11", tx_start, 1);
    tick();
    finish_data();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule